// File: doc/BRIEF.md
# Serial Receiver with Line Status Tracking

This block is the receive half of a classic asynchronous serial port. It watches a serial input with an oversampling enable supplied from outside. It detects and validates the start bit, then gathers 5 to 8 data bits and an optional parity bit, and checks the first stop bit. Each finished character is placed in a receive store. In buffered mode the store is a FIFO whose entries each carry their own parity, framing and break tags. In single mode the store is a one-character holding register.

Software reads the character at the head through `rbr_data` and pops it with `rd_rbr`. It reads the status byte `lsr` and marks that read with `rd_lsr`, which clears the sticky flags. A receiver line status interrupt is raised from the error flags when `rls_ie` is set.

The receiver runs one state machine. It has these states:
- `S_IDLE`: waits for a low sample.
- `S_START`: confirms the start bit at mid-bit and falls back to `S_IDLE` if the line is high again.
- `S_DATA`: takes a sample each bit period.
- `S_PARITY`: reached only if parity is enabled.
- `S_STOP`: samples the stop bit and delivers the character. From here the machine goes to `S_IDLE` after a good stop bit, to `S_START` on a framing error (resync), or to `S_BRK_WAIT` on a break.
- `S_BRK_WAIT`: holds until the line has been high for half a bit, then returns to `S_IDLE`.

Top module: `uart_rx_lsr`

## Requirements
- R1: `lsr[0]` (data ready) is 1 exactly while at least one received character is held. It becomes 1 in the cycle after a character is delivered, and 0 once every held character has been popped with `rd_rbr`. `rbr_data` shows the head character, and its bits above the word length read 0.
- R2: In buffered mode (`fifo_en`=1), a character that completes while the FIFO holds DEPTH entries is discarded and `lsr[1]` (overrun) sets. The entries already stored read back unchanged and in order.
- R3: In single mode (`fifo_en`=0), a character that completes while one is already held replaces it and sets `lsr[1]`.
- R4: Overrun, parity, framing and break flags set on detection. A `rd_lsr` pulse clears overrun, and it hides the head's tags until a different character becomes head. A new overrun in the same cycle wins over the clear.
- R5: `lsr[2]` (parity), `lsr[3]` (framing) and `lsr[4]` (break) show the tags of the head character only. Bits 5 and 6 read 0.
- R6: `lcr_wlen` encodes the word length as 5 plus its value (0 to 3), with data sent LSB first. When `lcr_par_en`=1 a parity bit follows the data. With `lcr_par_even`=1 the data and parity ones must be even in number; otherwise they must be odd. A mismatch tags parity.
- R7: A stop bit sampled 0 tags framing. The receiver then treats that low as a new start bit, samples it once more and receives the following bits as the next character.
- R8: When the start bit, all data bits, the parity bit and the stop bit are all sampled 0, exactly one character of data 0 with only the break tag is stored. No further character is taken until the line has been high for 8 consecutive oversample ticks.
- R9: `lsr[7]` reads 0 in single mode. In buffered mode it sets when a tagged character enters the FIFO, and a `rd_lsr` pulse clears it only if no tagged character remains.
- R10: `rls_irq` is 1 while `rls_ie`=1 and any of `lsr[4:1]` is 1.
- R11: After reset `lsr` reads 0x00 and `rls_irq` is 0.
- R12: A low pulse on `rxd` shorter than half a bit, measured at the mid-bit check, delivers no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Oversample enable, 16 per bit |
| rxd | input | 1 | Serial input, idle high |
| lcr_wlen | input | 2 | Word length minus 5 |
| lcr_par_en | input | 1 | Parity bit present |
| lcr_par_even | input | 1 | 1 = even parity, 0 = odd |
| fifo_en | input | 1 | 1 = buffered mode, 0 = single mode; changing it flushes the store |
| rls_ie | input | 1 | Line status interrupt enable |
| rd_rbr | input | 1 | Pop the head character |
| rd_lsr | input | 1 | Status read strobe |
| rbr_data | output | 8 | Head character |
| lsr | output | 8 | Line status byte |
| rls_irq | output | 1 | Receiver line status interrupt |

## Verification
The bench builds the block with DEPTH=4 and OVS=16, and holds `baud_tick` high so that one bit lasts 16 clocks. The shallow FIFO lets the buffered overrun and the ordering of entries around it be reached within five characters. The short bit time lets a multi-character break, a stop-bit resync straight into a second character, and a short idle blip inside the break all fit comfortably in a run.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PARITY, S_STOP, S_BRK_WAIT
    } rx_state_t;

    typedef struct packed {
        logic       bi;
        logic       fe;
        logic       pe;
        logic [7:0] data;
    } rx_char_t;

    function automatic logic has_tag(rx_char_t c);
        return c.bi | c.fe | c.pe;
    endfunction
endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic       par_even,
    output logic       char_vld,
    output rx_char_t   char_o
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    rx_state_t     state, state_n;
    logic [CW-1:0] cnt, cnt_n;
    logic [2:0]    bitn, bitn_n;
    logic [7:0]    sh, sh_n;
    logic          pbit, pbit_n, allz, allz_n;
    logic          vld_n;
    rx_char_t      chr_n;
    logic          brk, perr;
    logic [2:0]    last_bit;

    assign last_bit = 3'd4 + {1'b0, wlen};
    assign brk      = allz & ~rxd;
    assign perr     = par_even ? (^sh ^ pbit) : ~(^sh ^ pbit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cnt      <= '0;
            bitn     <= '0;
            sh       <= '0;
            pbit     <= 1'b0;
            allz     <= 1'b0;
            char_vld <= 1'b0;
            char_o   <= '0;
        end else begin
            state    <= state_n;
            cnt      <= cnt_n;
            bitn     <= bitn_n;
            sh       <= sh_n;
            pbit     <= pbit_n;
            allz     <= allz_n;
            char_vld <= vld_n;
            char_o   <= chr_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        bitn_n  = bitn;
        sh_n    = sh;
        pbit_n  = pbit;
        allz_n  = allz;
        vld_n   = 1'b0;
        chr_n   = char_o;
        unique case (state)
            S_IDLE: begin
                if (tick && !rxd) begin
                    state_n = S_START;
                    cnt_n   = '0;
                end
            end
            S_START: begin
                if (tick) begin
                    if (cnt == MID) begin
                        cnt_n = '0;
                        if (!rxd) begin
                            state_n = S_DATA;
                            bitn_n  = '0;
                            sh_n    = '0;
                            allz_n  = 1'b1;
                        end else begin
                            state_n = S_IDLE;
                        end
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            S_DATA: begin
                if (tick) begin
                    if (cnt == LAST) begin
                        cnt_n      = '0;
                        sh_n[bitn] = rxd;
                        allz_n     = allz & ~rxd;
                        bitn_n     = bitn + 1'b1;
                        if (bitn == last_bit)
                            state_n = par_en ? S_PARITY : S_STOP;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            S_PARITY: begin
                if (tick) begin
                    if (cnt == LAST) begin
                        cnt_n   = '0;
                        pbit_n  = rxd;
                        allz_n  = allz & ~rxd;
                        state_n = S_STOP;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            S_STOP: begin
                if (tick) begin
                    if (cnt == LAST) begin
                        vld_n      = 1'b1;
                        chr_n.data = sh;
                        chr_n.bi   = brk;
                        chr_n.fe   = ~rxd & ~brk;
                        chr_n.pe   = par_en & ~brk & perr;
                        cnt_n      = '0;
                        if (brk) begin
                            state_n = S_BRK_WAIT;
                        end else if (!rxd) begin
                            state_n = S_START;
                            cnt_n   = MID - 1'b1;
                        end else begin
                            state_n = S_IDLE;
                        end
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            S_BRK_WAIT: begin
                if (tick) begin
                    if (!rxd)
                        cnt_n = '0;
                    else if (cnt == MID)
                        state_n = S_IDLE;
                    else
                        cnt_n = cnt + 1'b1;
                end
            end
            default: state_n = S_IDLE;
        endcase
    end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          push,
    input  rx_char_t      din,
    input  logic          pop,
    output rx_char_t      head,
    output logic [CW-1:0] fcnt,
    output logic [CW-1:0] err_cnt,
    output logic          ovr,
    output logic          head_chg
);
    localparam int PW = $clog2(DEPTH);

    rx_char_t      mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          en_q, pop_ok, full, wr, owr;

    assign pop_ok   = pop && (fcnt != '0);
    assign full     = (fifo_en ? (fcnt == CW'(DEPTH)) : (fcnt != '0)) && !pop_ok;
    assign wr       = push && !full;
    assign ovr      = push && full;
    assign owr      = ovr && !fifo_en;
    assign head     = mem[rp];
    assign head_chg = pop_ok || (wr && fcnt == '0) || owr;

    always_ff @(posedge clk) begin
        if (wr)
            mem[wp] <= din;
        else if (owr)
            mem[rp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp      <= '0;
            rp      <= '0;
            fcnt    <= '0;
            err_cnt <= '0;
            en_q    <= 1'b0;
        end else begin
            en_q <= fifo_en;
            if (fifo_en != en_q) begin
                wp      <= '0;
                rp      <= '0;
                fcnt    <= '0;
                err_cnt <= '0;
            end else begin
                wp   <= wp + PW'(wr);
                rp   <= rp + PW'(pop_ok);
                fcnt <= fcnt + CW'(wr) - CW'(pop_ok);
                if (!fifo_en)
                    err_cnt <= '0;
                else
                    err_cnt <= err_cnt + CW'(wr && has_tag(din))
                                       - CW'(pop_ok && has_tag(head));
            end
        end
    end
endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OVS   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       rxd,
    input  logic [1:0] lcr_wlen,
    input  logic       lcr_par_en,
    input  logic       lcr_par_even,
    input  logic       fifo_en,
    input  logic       rls_ie,
    input  logic       rd_rbr,
    input  logic       rd_lsr,
    output logic [7:0] rbr_data,
    output logic [7:0] lsr,
    output logic       rls_irq
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [1:0]    sync;
    logic          char_vld, ovr, head_chg;
    rx_char_t      char_d, head;
    logic [CW-1:0] fcnt, err_cnt;
    logic          oe, mask, b7, dr, show;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end

    uart_rx_deser #(.OVS(OVS)) u_deser (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(sync[1]),
        .wlen(lcr_wlen), .par_en(lcr_par_en), .par_even(lcr_par_even),
        .char_vld(char_vld), .char_o(char_d)
    );

    uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push(char_vld),
        .din(char_d), .pop(rd_rbr), .head(head), .fcnt(fcnt),
        .err_cnt(err_cnt), .ovr(ovr), .head_chg(head_chg)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe   <= 1'b0;
            mask <= 1'b0;
            b7   <= 1'b0;
        end else begin
            if (ovr)         oe <= 1'b1;
            else if (rd_lsr) oe <= 1'b0;

            if (head_chg)    mask <= 1'b0;
            else if (rd_lsr) mask <= 1'b1;

            if (!fifo_en)                                  b7 <= 1'b0;
            else if (char_vld && !ovr && has_tag(char_d))  b7 <= 1'b1;
            else if (rd_lsr && err_cnt == '0)              b7 <= 1'b0;
        end
    end

    assign dr       = (fcnt != '0);
    assign show     = dr && !mask;
    assign rbr_data = dr ? head.data : 8'h00;
    assign lsr      = {b7, 2'b00, show & head.bi, show & head.fe, show & head.pe, oe, dr};
    assign rls_irq  = rls_ie && (lsr[4:1] != 4'b0000);
endmodule

// File: rtl/uart_rx_lsr_checker.sv
module uart_rx_lsr_checker #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          rd_lsr,
    input logic          rls_ie,
    input logic [7:0]    lsr,
    input logic          rls_irq,
    input logic          ovr,
    input logic          char_vld,
    input logic [CW-1:0] fcnt
);
    AST_DR_AFTER_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        char_vld && fifo_en == $past(fifo_en) |=> lsr[0]); // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fcnt <= CW'(DEPTH)); // R2

    AST_OE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lsr && !ovr |=> !lsr[1]); // R4

    AST_B7_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en && $past(!fifo_en) |-> !lsr[7]); // R9

    AST_IRQ_ON_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        ovr && rls_ie |=> !rls_ie || rls_irq); // R10
endmodule

bind uart_rx_lsr uart_rx_lsr_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rd_lsr(rd_lsr),
    .rls_ie(rls_ie), .lsr(lsr), .rls_irq(rls_irq), .ovr(ovr),
    .char_vld(char_vld), .fcnt(fcnt)
);

// File: tb/uart_rx_lsr_test.sv
module uart_rx_lsr_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic       rxd = 1'b1;
    logic [1:0] lcr_wlen = 2'b11;
    logic       lcr_par_en = 1'b0, lcr_par_even = 1'b0;
    logic       fifo_en = 1'b0, rls_ie = 1'b1;
    logic       rd_rbr = 1'b0, rd_lsr = 1'b0;
    logic [7:0] rbr_data, lsr;
    logic       rls_irq;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_rx_lsr #(.DEPTH(4), .OVS(16)) uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
        .lcr_wlen(lcr_wlen), .lcr_par_en(lcr_par_en), .lcr_par_even(lcr_par_even),
        .fifo_en(fifo_en), .rls_ie(rls_ie), .rd_rbr(rd_rbr), .rd_lsr(rd_lsr),
        .rbr_data(rbr_data), .lsr(lsr), .rls_irq(rls_irq)
    );

    // wlen[12:11] par_en[10] even[9] bad_parity[8] data[7:0]
    localparam logic [12:0] VEC [8] = '{
        {2'b11, 1'b0, 1'b0, 1'b0, 8'hA5},
        {2'b00, 1'b0, 1'b0, 1'b0, 8'hFF},
        {2'b01, 1'b1, 1'b1, 1'b0, 8'h2A},
        {2'b10, 1'b1, 1'b0, 1'b0, 8'h55},
        {2'b11, 1'b1, 1'b1, 1'b1, 8'hC3},
        {2'b11, 1'b1, 1'b0, 1'b0, 8'h00},
        {2'b00, 1'b1, 1'b0, 1'b1, 8'h13},
        {2'b10, 1'b1, 1'b1, 1'b0, 8'h7F}
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic b);
        rxd = b;
        repeat (16) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int nb, input logic pen, input logic ev,
                        input logic badp, input logic stopv, input logic with_start);
        logic p;
        p = 1'b0;
        if (with_start) drive(1'b0);
        for (int i = 0; i < nb; i++) begin
            drive(d[i]);
            p ^= d[i];
        end
        if (pen) drive((ev ? p : ~p) ^ badp);
        drive(stopv);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic read_lsr(input logic [7:0] exp, input string tag);
        check(lsr, exp, tag);
        rd_lsr = 1'b1;
        @(negedge clk);
        rd_lsr = 1'b0;
    endtask

    task automatic pop(input logic [7:0] exp, input string tag);
        check(rbr_data, exp, tag);
        rd_rbr = 1'b1;
        @(negedge clk);
        rd_rbr = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(lsr, 8'h00, "R11 lsr in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(lsr, 8'h00, "R11 lsr after reset");
        check({7'd0, rls_irq}, 8'h00, "R11 irq after reset");

        // R6 R5 R1 R10: vector walk in single mode
        for (int k = 0; k < 8; k++) begin
            logic [12:0] v;
            logic [7:0]  m;
            logic        perr;
            v = VEC[k];
            lcr_wlen = v[12:11]; lcr_par_en = v[10]; lcr_par_even = v[9];
            m = 8'hFF >> (3 - v[12:11]);
            perr = v[10] & v[8];
            send(v[7:0], 5 + int'(v[12:11]), v[10], v[9], v[8], 1'b1, 1'b1);
            check({7'd0, rls_irq}, {7'd0, perr}, $sformatf("R10 irq vec%0d", k));
            read_lsr({5'b0, perr, 2'b01}, $sformatf("R6 R5 lsr vec%0d", k));
            pop(v[7:0] & m, $sformatf("R6 data vec%0d", k));
            check(lsr, 8'h00, $sformatf("R1 empty vec%0d", k));
        end
        lcr_wlen = 2'b11; lcr_par_en = 1'b0;

        // R12: short low blip
        rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
        repeat (40) @(negedge clk);
        check(lsr, 8'h00, "R12 blip ignored");

        // R3: single-mode overrun replaces held char
        send(8'h11, 8, 0, 0, 0, 1, 1);
        send(8'h22, 8, 0, 0, 0, 1, 1);
        read_lsr(8'h03, "R3 overrun flagged");
        check(lsr, 8'h01, "R4 overrun cleared by read");
        pop(8'h22, "R3 newest kept");
        check(lsr, 8'h00, "R1 empty after overrun");

        // R8: break in single mode
        rxd = 1'b0; repeat (16 * 30) @(negedge clk);
        rxd = 1'b1; repeat (4) @(negedge clk);
        rxd = 1'b0; repeat (16 * 9) @(negedge clk);
        rxd = 1'b1; repeat (32) @(negedge clk);
        check({7'd0, rls_irq}, 8'h01, "R10 irq on break");
        read_lsr(8'h11, "R8 break tag");
        check(lsr, 8'h01, "R4 break tag hidden after read");
        pop(8'h00, "R8 break char zero");
        check(lsr, 8'h00, "R8 only one break char");
        send(8'h5A, 8, 0, 0, 0, 1, 1);
        pop(8'h5A, "R8 reception restarts");

        // R2: buffered overrun with DEPTH=4
        fifo_en = 1'b1; repeat (4) @(negedge clk);
        rls_ie = 1'b0;
        for (int k = 1; k <= 5; k++) send(8'(k), 8, 0, 0, 0, 1, 1);
        check({7'd0, rls_irq}, 8'h00, "R10 irq masked");
        read_lsr(8'h03, "R2 fifo overrun");
        for (int k = 1; k <= 4; k++) pop(8'(k), $sformatf("R2 order %0d", k));
        check(lsr, 8'h00, "R2 fifth dropped");
        rls_ie = 1'b1;

        // R5 R9: per-character tags
        lcr_par_en = 1'b1; lcr_par_even = 1'b1;
        send(8'h0F, 8, 1, 1, 0, 1, 1);
        send(8'hF1, 8, 1, 1, 1, 1, 1);
        send(8'h3C, 8, 1, 1, 0, 1, 1);
        read_lsr(8'h81, "R5 clean head");
        pop(8'h0F, "R5 data 1");
        read_lsr(8'h85, "R5 parity at head");
        pop(8'hF1, "R5 data 2");
        read_lsr(8'h81, "R9 bit7 sticky");
        check(lsr, 8'h01, "R9 bit7 cleared");
        pop(8'h3C, "R5 data 3");
        lcr_par_en = 1'b0;

        // R7: framing error then resync
        send(8'h35, 8, 0, 0, 0, 0, 1);
        send(8'hC3, 8, 0, 0, 0, 1, 0);
        read_lsr(8'h89, "R7 framing tag");
        pop(8'h35, "R7 bad-stop char");
        read_lsr(8'h81, "R7 resync head");
        pop(8'hC3, "R7 resync char");
        check(lsr, 8'h00, "R9 bit7 clear when empty");

        done = 1;
        summary();
        $finish;
    end
endmodule